// File: doc/BRIEF.md
# Two-Level Amplitude Keying Scaler

This block sits behind a sine source, typically a direct digital synthesizer, and keys the amplitude of that stream between two levels. It takes one signed 12-bit sample at a time, together with a level select. Each sample is multiplied by one of two fixed gains, 1024 for the high level or 307 for the low level. The product is held at 22 bits, and the lower 10 bits are removed with an arithmetic shift. The result is a signed 12-bit sample whose amplitude is full scale at the high level and about 0.3 of full scale at the low level.

The level select is captured with each sample, so switching between levels takes effect on exactly the sample presented alongside the new select value. One register stage sits between input and output, and a result appears one clock after the sample that produced it. Creating the sine waveform and smoothing the step between levels are done elsewhere.

Top module: `ask_level_scaler`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `out_valid` at 0 and `out_sample` at 0.
- R2: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low in the cycle after one at which `in_valid` was low.
- R3: With `level_hi` at 1 (high level, gain 1024), the output sample equals the input sample for every 12-bit two's-complement input value.
- R4: With `level_hi` at 0 (low level, gain 307), the output sample equals floor(x * 307 / 1024), where x is the input read as 12-bit two's complement.
- R5: Sign is kept and the discarded bits round toward negative infinity. At the low level, input -1 gives -1, input +1 gives 0, and a non-negative input never gives a negative output.
- R6: The gain applied to a sample is chosen by the `level_hi` value present at the same clock edge as that sample. Back-to-back samples with alternating `level_hi` each receive their own gain.
- R7: When `in_valid` is low at an edge, `out_sample` keeps its previous value.
- R8: Full-scale corners: -2048 at the high level gives -2048; -2048 at the low level gives -614; +2047 at the low level gives +613; +2047 at the high level gives +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sample | input | 12 | Signed input sample |
| in_valid | input | 1 | Input sample qualifier |
| level_hi | input | 1 | 1 selects gain 1024, 0 selects gain 307 |
| out_sample | output | 12 | Signed scaled sample |
| out_valid | output | 1 | Output sample qualifier |

## Verification
The block holds only the output register and its valid flag. A corrupted gain, select or shift shows up at the ports one cycle after the affected sample, as an output value wrong by a factor or by its sign. For that reason, each sample is compared against an independently computed floor division on the cycle its result appears. The high-level identity, the low-level rounding of small negative and positive inputs, and the full-scale corners catch faults in sign extension and rounding. Alternating selects on back-to-back samples catch a select that is delayed by one sample. Idle cycles catch an output that does not hold its value.

// File: rtl/akm_pkg.sv
// Package: shared constants and the level encoding for the amplitude keying scaler.
// Assumes gains never exceed 2**FRAC_W, so a shifted product fits the sample width.
package akm_pkg;
    localparam int DEF_DATA_W     = 12;
    localparam int DEF_FRAC_W     = 10;
    localparam int DEF_GAIN_HIGH  = 1024;
    localparam int DEF_GAIN_LOW   = 307;

    typedef enum logic {
        LEVEL_LOW  = 1'b0,
        LEVEL_HIGH = 1'b1
    } level_e;
endpackage

// File: rtl/akm_gain_sel.sv
// Gain selector: maps the level select to one of two fixed signed gain constants.
// Assumes both gains are non-negative and fit GAIN_W bits as signed values.
module akm_gain_sel #(
    parameter int GAIN_W    = 12,
    parameter int GAIN_HIGH = akm_pkg::DEF_GAIN_HIGH,
    parameter int GAIN_LOW  = akm_pkg::DEF_GAIN_LOW
) (
    input  akm_pkg::level_e          level,
    output logic signed [GAIN_W-1:0] gain
);
    localparam logic signed [GAIN_W-1:0] HIGH_C = GAIN_W'(GAIN_HIGH);
    localparam logic signed [GAIN_W-1:0] LOW_C  = GAIN_W'(GAIN_LOW);

    // Pick the gain constant for the requested level.
    always_comb begin
        gain = (level == akm_pkg::LEVEL_HIGH) ? HIGH_C : LOW_C;
    end
endmodule

// File: rtl/akm_scale.sv
// Scaler datapath: signed multiply at PROD_W bits, then arithmetic right shift by FRAC_W.
// Assumes PROD_W = DATA_W + FRAC_W and |gain| <= 2**FRAC_W, so nothing wraps.
module akm_scale #(
    parameter int DATA_W = akm_pkg::DEF_DATA_W,
    parameter int FRAC_W = akm_pkg::DEF_FRAC_W,
    parameter int GAIN_W = FRAC_W + 2
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] scaled
);
    localparam int PROD_W = DATA_W + FRAC_W;

    logic signed [PROD_W-1:0] sample_ext;
    logic signed [PROD_W-1:0] gain_ext;
    logic signed [PROD_W-1:0] product;

    // Sign-extend both operands to the product width.
    always_comb begin
        sample_ext = PROD_W'(sample);
        gain_ext   = PROD_W'(gain);
    end

    // Form the product and drop the fraction bits, rounding toward minus infinity.
    always_comb begin
        product = sample_ext * gain_ext;
        scaled  = DATA_W'(product >>> FRAC_W);
    end
endmodule

// File: rtl/ask_level_scaler.sv
// Top: two-level amplitude keying of a signed sample stream with one register stage.
// Assumes the level select is valid together with each sample; reset is synchronous, active low.
module ask_level_scaler #(
    parameter int DATA_W    = akm_pkg::DEF_DATA_W,
    parameter int FRAC_W    = akm_pkg::DEF_FRAC_W,
    parameter int GAIN_HIGH = akm_pkg::DEF_GAIN_HIGH,
    parameter int GAIN_LOW  = akm_pkg::DEF_GAIN_LOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_valid,
    input  logic              level_hi,
    output logic [DATA_W-1:0] out_sample,
    output logic              out_valid
);
    localparam int GAIN_W = FRAC_W + 2;

    akm_pkg::level_e          level;
    logic signed [GAIN_W-1:0] gain;
    logic signed [DATA_W-1:0] scaled;

    // Decode the raw select into the level type.
    always_comb begin
        level = level_hi ? akm_pkg::LEVEL_HIGH : akm_pkg::LEVEL_LOW;
    end

    akm_gain_sel #(
        .GAIN_W    (GAIN_W),
        .GAIN_HIGH (GAIN_HIGH),
        .GAIN_LOW  (GAIN_LOW)
    ) u_gain (
        .level (level),
        .gain  (gain)
    );

    akm_scale #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .GAIN_W (GAIN_W)
    ) u_scale (
        .sample (signed'(in_sample)),
        .gain   (gain),
        .scaled (scaled)
    );

    // Output register: capture a scaled sample on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= scaled;
            end
        end
    end

    // R2: valid follows input valid by one cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3: high level passes the sample through unchanged.
    a_r3_high_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && level_hi) |=> (out_sample == $past(in_sample)));
    // R5: a non-negative input at the low level never comes out negative.
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !level_hi && !in_sample[DATA_W-1]) |=> !out_sample[DATA_W-1]);
    // R7: output holds while no sample arrives.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
endmodule

// File: tb/sim_ask_level_scaler.sv
`timescale 1ns/1ps
module sim_ask_level_scaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] in_sample = '0;
    logic        in_valid = 1'b0;
    logic        level_hi = 1'b0;
    logic [11:0] out_sample;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];
    logic [11:0] last_exp = '0;
    bit          have_last = 0;

    always #4 clk = ~clk;

    ask_level_scaler u0 (
        .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .in_valid(in_valid),
        .level_hi(level_hi), .out_sample(out_sample), .out_valid(out_valid)
    );

    function automatic int floor_div(int num, int den);
        int q;
        q = num / den;
        if ((num % den != 0) && (num < 0)) q = q - 1;
        return q;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: present one sample and push the expected output.
    task automatic send(int x, bit hi, string tag);
        int e;
        @(posedge clk); #1;
        in_sample = 12'(x);
        in_valid  = 1'b1;
        level_hi  = hi;
        e = hi ? x : floor_div(x * 307, 1024);
        exp_q.push_back(12'(e));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid  = 1'b0;
            in_sample = 12'h5A5;
            level_hi  = ~level_hi;
        end
    endtask

    // Monitor: compare outputs against the scoreboard between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected valid", 1, 0);
                end else begin
                    logic [11:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_sample == e, t, $signed(out_sample), $signed(e));
                    last_exp  = e;
                    have_last = 1;
                end
            end else if (have_last) begin
                check(out_sample == last_exp, "R7 hold", $signed(out_sample), $signed(last_exp));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(out_sample == 12'd0, "R1 reset sample", out_sample, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        send(100, 1, "R3 high +100");
        send(-1234, 1, "R3 high -1234");
        send(1000, 0, "R4 low +1000");
        send(-1000, 0, "R4 low -1000");
        send(-1, 0, "R5 low -1");
        send(1, 0, "R5 low +1");
        send(3, 0, "R5 low +3");
        idle(3);
        send(-2048, 1, "R8 high -2048");
        send(-2048, 0, "R8 low -2048");
        send(2047, 0, "R8 low +2047");
        send(2047, 1, "R8 high +2047");
        send(500, 1, "R6 alt high");
        send(500, 0, "R6 alt low");
        send(500, 1, "R6 alt high again");
        send(-777, 0, "R6 alt low neg");
        idle(2);
        for (int x = -2048; x < 2048; x += 37) begin
            send(x, x[0], "R4 sweep");
        end
        idle(4);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 drained", out_valid, 0);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule